// File: doc/BRIEF.md
# Shared-MAC FIR Filter Controller

This block is a finite impulse response filter that computes every output with a single multiply-accumulate unit. It works through the taps one at a time, so one output costs several clock cycles instead of one multiplier per tap. After reset, a control state machine first fills an on-chip coefficient memory from a write port. It writes one coefficient for each strobe, in tap order. After that it waits in a restart state for an input sample. For each accepted sample it clears the accumulator and steps a single address through the coefficient memory and the sample history. It reads one tap per cycle. Once the last tap has been added, the full-precision sum appears on the output with a one-cycle valid pulse.

An upstream producer offers samples with a valid strobe and must hold each sample until the block raises its ready signal. Ready is high only while the machine rests in its restart state. The coefficient port is meant for the initial load only. Outputs use simple two's-complement arithmetic, and the accumulator is sized so that no input pattern can overflow it.

Top module: `tmfir_core`

## Requirements
- R1: While reset is high, and on the first cycle after it, `smp_ready` and `res_valid` are 0 and `res_data` is 0.
- R2: `smp_ready` stays 0 until NTAPS coefficient strobes have been received. It reads 1 on the cycle right after the clock edge that captured the last of them.
- R3: Coefficient strobes that arrive after the load has completed have no effect on any later output.
- R4: For each accepted sample x[n], the output equals the sum over k = 0..NTAPS-1 of c[k]·x[n-k]. Here c[k] is the k-th coefficient written (the first write is c[0]). Samples and coefficients are signed two's complement, and history before the first sample after reset counts as zero.
- R5: `res_valid` goes high for exactly one cycle. This happens on the (NTAPS+1)-th rising edge after the edge that accepted the sample.
- R6: After an accepting edge, `smp_ready` is 0 for NTAPS cycles. It returns to 1 in the cycle in which the last product is being accumulated, so back-to-back samples are taken every NTAPS+1 cycles.
- R7: A sample offered while `smp_ready` is 0, including during the coefficient load, is not taken into the history.
- R8: The accumulator is SAMPLE_W+COEF_W+log2(NTAPS) bits wide. With every coefficient and sample at the most negative value, the exact positive sum is produced (262144 at the defaults).
- R9: Each output starts from a cleared accumulator, so no part of a previous sum carries into the next one.
- R10: `res_data` keeps its value between valid pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cf_wr | input | 1 | Coefficient write strobe (honoured during load only) |
| cf_data | input | COEF_W | Signed coefficient for the next tap position |
| smp_valid | input | 1 | Input sample offered |
| smp_data | input | SAMPLE_W | Signed input sample |
| smp_ready | output | 1 | Block can accept a sample this cycle |
| res_valid | output | 1 | One-cycle pulse: `res_data` holds a new output |
| res_data | output | SAMPLE_W+COEF_W+log2(NTAPS) | Signed filter output |

## Verification
Two things can happen in the same cycle: the final product of one pass is being added into the accumulator, and the next sample is accepted and shifted into the history. The bench provokes this by holding `smp_valid` high continuously, with the sample value changing every cycle. A behavioural model, built on integer arrays, predicts the output that should follow from the accepted samples only. Its results are compared with the ports on every cycle. If either overlapping action corrupts the other, a wrong sum or a mistimed ready shows up at once. Stray coefficient writes during that stream test that the loaded taps are left untouched.

// File: rtl/tmfir_pkg.sv
package tmfir_pkg;
  typedef enum logic [1:0] {
    ST_LOAD    = 2'd0,
    ST_RESTART = 2'd1,
    ST_RUN     = 2'd2
  } fsm_t;
endpackage

// File: rtl/tmfir_ctrl.sv
module tmfir_ctrl
  import tmfir_pkg::*;
#(
  parameter int NTAPS  = 16,
  parameter int ADDR_W = $clog2(NTAPS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cf_wr,
  input  logic              smp_valid,
  output logic [ADDR_W-1:0] addr,
  output logic              mem_wen,
  output logic              acc_rst,
  output logic              ready,
  output logic              shift_en,
  output logic              rd_vld,
  output logic              rd_first,
  output logic              rd_last
);
  localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(NTAPS - 1);

  fsm_t state;

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_LOAD;
      addr  <= '0;
    end else begin
      unique case (state)
        ST_LOAD: begin
          if (cf_wr) begin
            if (addr == LAST_ADDR) begin
              state <= ST_RESTART;
              addr  <= '0;
            end else begin
              addr <= addr + 1'b1;
            end
          end
        end
        ST_RESTART: begin
          addr <= '0;
          if (smp_valid) state <= ST_RUN;
        end
        ST_RUN: begin
          if (addr == LAST_ADDR) begin
            state <= ST_RESTART;
            addr  <= '0;
          end else begin
            addr <= addr + 1'b1;
          end
        end
        default: begin
          state <= ST_LOAD;
          addr  <= '0;
        end
      endcase
    end
  end

  always_comb begin
    mem_wen  = (state == ST_LOAD) && cf_wr;
    ready    = (state == ST_RESTART);
    acc_rst  = (state == ST_RESTART);
    shift_en = ready && smp_valid;
    rd_vld   = (state == ST_RUN);
    rd_first = rd_vld && (addr == '0);
    rd_last  = rd_vld && (addr == LAST_ADDR);
  end
endmodule

// File: rtl/tmfir_coef_mem.sv
module tmfir_coef_mem #(
  parameter int DEPTH  = 16,
  parameter int ADDR_W = $clog2(DEPTH),
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/tmfir_delay_line.sv
module tmfir_delay_line #(
  parameter int DEPTH  = 16,
  parameter int ADDR_W = $clog2(DEPTH),
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              shift_en,
  input  logic [DATA_W-1:0] din,
  input  logic [ADDR_W-1:0] sel,
  output logic [DATA_W-1:0] dout
);
  logic [DATA_W-1:0] taps [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) taps[0] <= '0;
    else if (shift_en) taps[0] <= din;
  end

  for (genvar i = 1; i < DEPTH; i++) begin : g_tap
    always_ff @(posedge clk) begin
      if (rst) taps[i] <= '0;
      else if (shift_en) taps[i] <= taps[i-1];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) dout <= '0;
    else dout <= taps[sel];
  end
endmodule

// File: rtl/tmfir_mac.sv
module tmfir_mac #(
  parameter int A_W   = 8,
  parameter int B_W   = 8,
  parameter int ACC_W = 20
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             vld,
  input  logic             first,
  input  logic             last,
  input  logic             acc_rst,
  input  logic [A_W-1:0]   a,
  input  logic [B_W-1:0]   b,
  output logic             res_valid,
  output logic [ACC_W-1:0] res_data
);
  localparam int PROD_W = A_W + B_W;

  logic signed [PROD_W-1:0] prod;
  logic signed [ACC_W-1:0]  prod_ext;
  logic signed [ACC_W-1:0]  acc;
  logic signed [ACC_W-1:0]  sum;

  always_comb begin
    prod     = $signed(a) * $signed(b);
    prod_ext = {{(ACC_W-PROD_W){prod[PROD_W-1]}}, prod};
    sum      = (first ? '0 : acc) + prod_ext;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc       <= '0;
      res_valid <= 1'b0;
      res_data  <= '0;
    end else begin
      res_valid <= vld && last;
      if (vld) acc <= sum;
      else if (acc_rst) acc <= '0;
      if (vld && last) res_data <= sum;
    end
  end
endmodule

// File: rtl/tmfir_core.sv
module tmfir_core #(
  parameter int NTAPS    = 16,
  parameter int SAMPLE_W = 8,
  parameter int COEF_W   = 8,
  parameter int ACC_W    = SAMPLE_W + COEF_W + $clog2(NTAPS)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                cf_wr,
  input  logic [COEF_W-1:0]   cf_data,
  input  logic                smp_valid,
  input  logic [SAMPLE_W-1:0] smp_data,
  output logic                smp_ready,
  output logic                res_valid,
  output logic [ACC_W-1:0]    res_data
);
  localparam int ADDR_W = $clog2(NTAPS);

  logic [ADDR_W-1:0]   addr;
  logic                mem_wen, acc_rst, shift_en;
  logic                rd_vld, rd_first, rd_last;
  logic                vld_q, first_q, last_q;
  logic [COEF_W-1:0]   coef_q;
  logic [SAMPLE_W-1:0] samp_q;

  tmfir_ctrl #(.NTAPS(NTAPS), .ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rst(rst), .cf_wr(cf_wr), .smp_valid(smp_valid),
    .addr(addr), .mem_wen(mem_wen), .acc_rst(acc_rst), .ready(smp_ready),
    .shift_en(shift_en), .rd_vld(rd_vld), .rd_first(rd_first), .rd_last(rd_last)
  );

  tmfir_coef_mem #(.DEPTH(NTAPS), .ADDR_W(ADDR_W), .DATA_W(COEF_W)) u_mem (
    .clk(clk), .we(mem_wen), .waddr(addr), .wdata(cf_data),
    .raddr(addr), .rdata(coef_q)
  );

  tmfir_delay_line #(.DEPTH(NTAPS), .ADDR_W(ADDR_W), .DATA_W(SAMPLE_W)) u_hist (
    .clk(clk), .rst(rst), .shift_en(shift_en), .din(smp_data),
    .sel(addr), .dout(samp_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q   <= 1'b0;
      first_q <= 1'b0;
      last_q  <= 1'b0;
    end else begin
      vld_q   <= rd_vld;
      first_q <= rd_first;
      last_q  <= rd_last;
    end
  end

  tmfir_mac #(.A_W(COEF_W), .B_W(SAMPLE_W), .ACC_W(ACC_W)) u_mac (
    .clk(clk), .rst(rst), .vld(vld_q), .first(first_q), .last(last_q),
    .acc_rst(acc_rst), .a(coef_q), .b(samp_q),
    .res_valid(res_valid), .res_data(res_data)
  );
endmodule

// File: rtl/tmfir_chk.sv
module tmfir_chk #(
  parameter int OUT_W = 20
) (
  input logic             clk,
  input logic             rst,
  input logic             smp_valid,
  input logic             smp_ready,
  input logic             res_valid,
  input logic [OUT_W-1:0] res_data
);
  p_reset_quiet_r1: assert property (@(posedge clk)
    rst |=> (!res_valid && !smp_ready));

  p_single_pulse_r5: assert property (@(posedge clk) disable iff (rst)
    res_valid |=> !res_valid);

  p_busy_after_take_r6: assert property (@(posedge clk) disable iff (rst)
    (smp_valid && smp_ready) |=> !smp_ready);

  p_hold_data_r10: assert property (@(posedge clk) disable iff (rst)
    (!res_valid && !$past(rst)) |-> $stable(res_data));
endmodule

bind tmfir_core tmfir_chk #(.OUT_W(ACC_W)) u_chk (
  .clk(clk), .rst(rst), .smp_valid(smp_valid), .smp_ready(smp_ready),
  .res_valid(res_valid), .res_data(res_data)
);

// File: tb/tmfir_core_tb.sv
module tmfir_core_tb;
  localparam int N  = 16;
  localparam int SW = 8;
  localparam int CW = 8;
  localparam int AW = SW + CW + $clog2(N);

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cf_wr = 1'b0;
  logic [CW-1:0] cf_data = '0;
  logic          smp_valid = 1'b0;
  logic [SW-1:0] smp_data = '0;
  logic          smp_ready;
  logic          res_valid;
  logic [AW-1:0] res_data;

  int checks = 0;
  int fails  = 0;
  string note = "R4 start";

  always #4 clk = ~clk;

  tmfir_core #(.NTAPS(N), .SAMPLE_W(SW), .COEF_W(CW)) u_dut (
    .clk(clk), .rst(rst), .cf_wr(cf_wr), .cf_data(cf_data),
    .smp_valid(smp_valid), .smp_data(smp_data), .smp_ready(smp_ready),
    .res_valid(res_valid), .res_data(res_data)
  );

  task automatic chk(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference model
  int     mc [N];
  int     hist [N];
  int     ld, cnt;
  longint pend, m_out;
  bit     m_ov, m_rdy, take;

  always @(posedge clk) begin
    if (rst) begin
      ld = 0; cnt = 0; m_ov = 0; m_out = 0; pend = 0;
      for (int i = 0; i < N; i++) hist[i] = 0;
    end else begin
      m_ov = 0;
      if (cnt == 1) begin m_ov = 1; m_out = pend; end
      take = (ld == N) && (cnt <= 1);
      if (cnt > 0) cnt--;
      if (ld < N) begin
        if (cf_wr) begin mc[ld] = $signed(cf_data); ld++; end
      end else if (take && smp_valid) begin
        for (int i = N - 1; i > 0; i--) hist[i] = hist[i-1];
        hist[0] = $signed(smp_data);
        pend = 0;
        for (int k = 0; k < N; k++) pend += longint'(mc[k]) * hist[k];
        cnt = N + 1;
      end
    end
    m_rdy = (ld == N) && (cnt <= 1);
  end

  // cycle-by-cycle comparison away from the active edge
  always @(negedge clk) begin
    if (!rst) begin
      chk("R6 ready", longint'(smp_ready), longint'(m_rdy));
      chk("R5 valid", longint'(res_valid), longint'(m_ov));
      if (res_valid) chk({"R4 ", note}, longint'($signed(res_data)), m_out);
      else           chk("R10 hold", longint'($signed(res_data)), m_out);
    end
  end

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++; checks++;
      $display("FAIL watchdog: actual %0d expected below 150000 cycles", cyc);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic do_reset();
    rst = 1'b1; cf_wr = 1'b0; smp_valid = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 ready", longint'(smp_ready), 0);
    chk("R1 valid", longint'(res_valid), 0);
    chk("R1 data", longint'(res_data), 0);
  endtask

  task automatic load(input int mode);
    for (int k = 0; k < N; k++) begin
      if (k % 3 == 2) begin cf_wr = 1'b0; @(negedge clk); end
      cf_wr = 1'b1;
      cf_data = (mode == 0) ? CW'((k * 37 + 11) % 256 - 128) : CW'(-128);
      @(negedge clk);
      if (k < N - 1) chk("R2 locked", longint'(smp_ready), 0);
    end
    cf_wr = 1'b0;
    chk("R2 open", longint'(smp_ready), 1);
  endtask

  task automatic send(input int v);
    while (!smp_ready) @(negedge clk);
    smp_valid = 1'b1; smp_data = SW'(v);
    @(negedge clk);
    smp_valid = 1'b0;
  endtask

  logic [15:0] lfsr = 16'hACE1;

  initial begin
    do_reset();
    // R7: samples offered during the load must be ignored
    smp_valid = 1'b1; smp_data = 8'd55;
    load(0);
    smp_valid = 1'b0;
    note = "R9 impulse";
    send(1);
    for (int i = 0; i < N + 2; i++) send(0);
    note = "R7 R3 stream";
    smp_valid = 1'b1;
    for (int i = 0; i < 120; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      smp_data = lfsr[7:0];
      cf_wr = lfsr[9];
      cf_data = lfsr[15:8];
      @(negedge clk);
    end
    smp_valid = 1'b0; cf_wr = 1'b0;
    note = "R4 spaced";
    for (int i = 0; i < 6; i++) begin
      send(i * 40 - 100);
      repeat (i * 5) @(negedge clk);
    end
    repeat (N + 4) @(negedge clk);
    do_reset();
    load(1);
    note = "R8 extreme";
    for (int i = 0; i < N; i++) send(-128);
    repeat (N + 4) @(negedge clk);
    chk("R8 full scale", longint'($signed(res_data)), 262144);
    note = "R9 partial";
    send(0);
    repeat (N + 4) @(negedge clk);
    chk("R9 fresh sum", longint'($signed(res_data)), 245760);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule